// File: doc/BRIEF.md
# Clamped Fixed-Point PI Compensator

This block computes one step of a proportional-integral control law each time it is started. It takes a 10-bit unsigned setpoint and a 10-bit unsigned measurement, forms a scaled error from them, and combines that error with two signed fractional gains. The integral term is kept in a wide saturating register. The combined value is rounded back to a 16-bit fraction. It is then limited below at zero and above at a programmable ceiling.

The same block serves an outer bus-voltage loop and an inner inductor-current loop. In the voltage loop the setpoint is typically 805 counts and the ceiling is left at full scale. In the current loop the ceiling is 30145, about 92 % of full scale. The limited result is also multiplied by a PWM period to give a duty count in period units. A start pulse samples all inputs. One step later a single-cycle done flag marks fresh outputs, which then hold until the next step completes.

Top module: `pi_clamp_comp`

## Requirements
- R1: On the clock edge where start is sampled high while idle, the error is formed as (refIn − fbIn) × 32, with both inputs treated as unsigned, giving a signed 16-bit fraction with 15 fraction bits. kpIn, kiIn, clampMax and period are sampled on the same edge, and later changes to any input do not affect that step.
- R2: Each step adds the 32-bit product kiIn × error, sign-extended and aligned at bit 0, to a signed 40-bit integral sum.
- R3: The integral sum, and the sum plus the proportional product, saturate at the signed 40-bit limits instead of wrapping.
- R4: The step output is (sum + kpIn × error + 2^14) shifted right arithmetically by 15, saturated to at most 32767. Products below half an output LSB round down, and products at half an LSB round up.
- R5: A negative step output is replaced by 0.
- R6: A step output above clampMax (unsigned) is replaced by clampMax.
- R7: duty equals floor(result × period / 2^15), where period is unsigned 16-bit.
- R8: done is high for exactly one cycle. It is seen in the third cycle after the edge that samples start. result and duty change on the edge that raises done. A start that arrives before done has been raised is ignored.
- R9: A synchronous active-high rst clears the integral sum, result, duty and done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins one compensator step when idle |
| refIn | input | 10 | Setpoint, unsigned counts |
| fbIn | input | 10 | Measured value, unsigned counts |
| kpIn | input | 16 | Proportional gain, signed Q15 |
| kiIn | input | 16 | Integral gain, signed Q15 |
| clampMax | input | 16 | Upper limit of result |
| period | input | 16 | PWM period used to scale the duty |
| result | output | 16 | Limited compensator output, Q15 |
| duty | output | 16 | result scaled by period |
| done | output | 1 | One-cycle pulse when result and duty update |

## Verification
The assertions assume that start is never driven while the clock edge samples reset. They also assume that the integral product keeps one sign during each step, so that a saturating sum can only move in the direction of that product. The stimulus keeps start in step with the negative clock edge and holds each operand stable until done. It reaches the 40-bit limit only through many repeated steps at full-scale gain and error, so the integrator direction check is exercised right at the saturation boundary.

// File: rtl/pi_clamp_pkg.sv
package pi_clamp_pkg;

  typedef struct packed {
    logic loadErr;
    logic updInt;
    logic latchOut;
  } piStrobes_t;

endpackage

// File: rtl/pi_clamp_ctrl.sv
module pi_clamp_ctrl
  import pi_clamp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output piStrobes_t strobes,
  output logic       done
);

  typedef enum logic [1:0] {S_IDLE, S_INT, S_OUT} state_t;

  state_t state;

  always_comb begin
    strobes.loadErr  = start && (state == S_IDLE);
    strobes.updInt   = (state == S_INT);
    strobes.latchOut = (state == S_OUT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      done <= strobes.latchOut;
      unique case (state)
        S_IDLE:  if (start) state <= S_INT;
        S_INT:   state <= S_OUT;
        S_OUT:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8: only one step phase at a time
  p_strobe_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.loadErr, strobes.updInt, strobes.latchOut}));

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: a load is always followed by the integrator update
  p_load_then_int_r8: assert property (@(posedge clk) disable iff (rst)
    strobes.loadErr |=> strobes.updInt);

endmodule

// File: rtl/pi_clamp_datapath.sv
module pi_clamp_datapath
  import pi_clamp_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int COEF_W    = 16,
  parameter int ACC_W     = 40,
  parameter int ERR_SHIFT = 5,
  parameter int FRAC      = 15,
  parameter int PER_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  piStrobes_t        strobes,
  input  logic [DATA_W-1:0] refIn,
  input  logic [DATA_W-1:0] fbIn,
  input  logic [COEF_W-1:0] kpIn,
  input  logic [COEF_W-1:0] kiIn,
  input  logic [COEF_W-1:0] clampMax,
  input  logic [PER_W-1:0]  period,
  output logic [COEF_W-1:0] result,
  output logic [PER_W-1:0]  duty
);

  localparam int ERR_W  = DATA_W + 1 + ERR_SHIFT;
  localparam int PROD_W = COEF_W + ERR_W;
  localparam int OUT_W  = COEF_W;
  localparam int DUTY_W = OUT_W + PER_W;
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W:0] HALF_LSB = (ACC_W+1)'(1) <<< (FRAC-1);

  logic signed [ERR_W-1:0]  errReg;
  logic signed [COEF_W-1:0] kpReg, kiReg;
  logic [OUT_W-1:0]         clampReg;
  logic [PER_W-1:0]         periodReg;
  logic signed [ACC_W-1:0]  sumReg, totReg;

  logic signed [DATA_W:0]   diff;
  logic signed [PROD_W-1:0] kiProd, kpProd;
  logic signed [ACC_W-1:0]  sumNext, totNext;
  logic signed [ACC_W:0]    rounded, shifted;
  logic [OUT_W-1:0]         clipVal;
  logic [DUTY_W-1:0]        dutyFull;

  function automatic logic signed [ACC_W-1:0] satAcc(input logic signed [ACC_W:0] v);
    if (v[ACC_W] != v[ACC_W-1]) return v[ACC_W] ? ACC_MIN : ACC_MAX;
    return v[ACC_W-1:0];
  endfunction

  always_comb begin
    diff    = $signed({1'b0, refIn}) - $signed({1'b0, fbIn});
    kiProd  = kiReg * errReg;
    kpProd  = kpReg * errReg;
    sumNext = satAcc((ACC_W+1)'(sumReg) + (ACC_W+1)'(kiProd));
    totNext = satAcc((ACC_W+1)'(sumNext) + (ACC_W+1)'(kpProd));
    rounded = (ACC_W+1)'(totReg) + HALF_LSB;
    shifted = rounded >>> FRAC;
    if (shifted[ACC_W])
      clipVal = '0;
    else if (|shifted[ACC_W-1:OUT_W-1])
      clipVal = OUT_MAX;
    else
      clipVal = shifted[OUT_W-1:0];
    if (clipVal > clampReg) clipVal = clampReg;
    dutyFull = DUTY_W'(clipVal) * DUTY_W'(periodReg);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      errReg    <= '0;
      kpReg     <= '0;
      kiReg     <= '0;
      clampReg  <= '0;
      periodReg <= '0;
      sumReg    <= '0;
      totReg    <= '0;
      result    <= '0;
      duty      <= '0;
    end else begin
      if (strobes.loadErr) begin
        errReg    <= {diff, {ERR_SHIFT{1'b0}}};
        kpReg     <= $signed(kpIn);
        kiReg     <= $signed(kiIn);
        clampReg  <= clampMax;
        periodReg <= period;
      end
      if (strobes.updInt) begin
        sumReg <= sumNext;
        totReg <= totNext;
      end
      if (strobes.latchOut) begin
        result <= clipVal;
        duty   <= PER_W'(dutyFull >> FRAC);
      end
    end
  end

  // R3: a saturating sum never moves against the sign of the integral product
  p_sum_direction_r3: assert property (@(posedge clk) disable iff (rst)
    strobes.updInt |=> ($past(kiProd) >= 0) ? (sumReg >= $past(sumReg))
                                            : (sumReg <= $past(sumReg)));

  // R5: the published result is never negative
  p_result_nonneg_r5: assert property (@(posedge clk) disable iff (rst)
    !result[OUT_W-1]);

  // R6: the published result respects the ceiling captured for its step
  p_clamp_r6: assert property (@(posedge clk) disable iff (rst)
    strobes.latchOut |=> result <= $past(clampReg));

  // R7: the duty never exceeds the period captured for its step
  p_duty_bound_r7: assert property (@(posedge clk) disable iff (rst)
    strobes.latchOut |=> duty <= $past(periodReg));

  // R9: reset clears the integrator and the outputs
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (sumReg == '0) && (result == '0) && (duty == '0));

endmodule

// File: rtl/pi_clamp_comp.sv
module pi_clamp_comp
  import pi_clamp_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int COEF_W    = 16,
  parameter int ACC_W     = 40,
  parameter int ERR_SHIFT = 5,
  parameter int FRAC      = 15,
  parameter int PER_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] refIn,
  input  logic [DATA_W-1:0] fbIn,
  input  logic [COEF_W-1:0] kpIn,
  input  logic [COEF_W-1:0] kiIn,
  input  logic [COEF_W-1:0] clampMax,
  input  logic [PER_W-1:0]  period,
  output logic [COEF_W-1:0] result,
  output logic [PER_W-1:0]  duty,
  output logic              done
);

  piStrobes_t strobes;

  pi_clamp_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .strobes (strobes),
    .done    (done)
  );

  pi_clamp_datapath #(
    .DATA_W    (DATA_W),
    .COEF_W    (COEF_W),
    .ACC_W     (ACC_W),
    .ERR_SHIFT (ERR_SHIFT),
    .FRAC      (FRAC),
    .PER_W     (PER_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .refIn    (refIn),
    .fbIn     (fbIn),
    .kpIn     (kpIn),
    .kiIn     (kiIn),
    .clampMax (clampMax),
    .period   (period),
    .result   (result),
    .duty     (duty)
  );

endmodule

// File: tb/pi_clamp_comp_bench.sv
module pi_clamp_comp_bench;

  typedef struct packed {
    logic [9:0]  r;
    logic [9:0]  f;
    logic [15:0] kp;
    logic [15:0] ki;
    logic [15:0] cl;
    logic [15:0] per;
    logic [15:0] expRes;
    logic [15:0] expDuty;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{10'd600,  10'd500, 16'd16384, 16'd8192,  16'd30145, 16'd1000,  16'd2400,  16'd73},
    '{10'd500,  10'd600, 16'd16384, 16'd8192,  16'd30145, 16'd1000,  16'd0,     16'd0},
    '{10'd805,  10'd0,   16'd32767, 16'd0,     16'd30145, 16'd2000,  16'd25759, 16'd1572},
    '{10'd1023, 10'd0,   16'd32767, 16'd32767, 16'd30145, 16'd4000,  16'd30145, 16'd3679},
    '{10'd1,    10'd0,   16'd512,   16'd0,     16'd30145, 16'd65535, 16'd1,     16'd1},
    '{10'd1,    10'd0,   16'd511,   16'd0,     16'd30145, 16'd65535, 16'd0,     16'd0},
    '{10'd10,   10'd10,  16'd1000,  16'd1000,  16'd30145, 16'd1000,  16'd0,     16'd0},
    '{10'd600,  10'd500, 16'd16384, 16'd8192,  16'd1000,  16'd1000,  16'd1000,  16'd30},
    '{10'd500,  10'd600, 16'hC000,  16'd0,     16'd30145, 16'd1000,  16'd1600,  16'd48}
  };

  localparam longint ACC_MAX = 64'sd549755813887;
  localparam longint ACC_MIN = -64'sd549755813888;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [9:0]  refIn = '0;
  logic [9:0]  fbIn = '0;
  logic [15:0] kpIn = '0;
  logic [15:0] kiIn = '0;
  logic [15:0] clampMax = '0;
  logic [15:0] period = '0;
  logic [15:0] result;
  logic [15:0] duty;
  logic        done;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;
  longint modelSum = 0;

  always #5 clk = ~clk;

  pi_clamp_comp u_pi_clamp_comp (
    .clk(clk), .rst(rst), .start(start), .refIn(refIn), .fbIn(fbIn),
    .kpIn(kpIn), .kiIn(kiIn), .clampMax(clampMax), .period(period),
    .result(result), .duty(duty), .done(done)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint sat40(input longint v);
    if (v > ACC_MAX) return ACC_MAX;
    if (v < ACC_MIN) return ACC_MIN;
    return v;
  endfunction

  // bench model of one step, from the requirements
  task automatic modelStep(input int r, input int f, input int kp, input int ki,
                           input int cl, input int per, output int eRes, output int eDuty);
    longint e, tot, q;
    e = longint'(r - f) * 32;
    modelSum = sat40(modelSum + longint'(ki) * e);
    tot = sat40(modelSum + longint'(kp) * e);
    q = (tot + 16384) >>> 15;
    if (q > 32767) q = 32767;
    if (q < 0) q = 0;
    if (q > cl) q = cl;
    eRes = int'(q);
    eDuty = int'((q * per) >>> 15);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    modelSum = 0;
  endtask

  // one step; optional second start while busy; optional done timing checks
  task automatic doCall(input int r, input int f, input int kp, input int ki,
                        input int cl, input int per, input bit extra, input bit chkT,
                        output int aRes, output int aDuty);
    @(negedge clk);
    refIn = 10'(r); fbIn = 10'(f); kpIn = 16'(kp); kiIn = 16'(ki);
    clampMax = 16'(cl); period = 16'(per); start = 1'b1;
    @(negedge clk);
    start = extra;
    refIn = ~refIn; kpIn = ~kpIn;
    if (chkT) chk("R8 done low one cycle after start", done, 0);
    @(negedge clk);
    start = 1'b0;
    if (chkT) chk("R8 done low two cycles after start", done, 0);
    @(negedge clk);
    if (chkT) chk("R8 done high three cycles after start", done, 1);
    aRes = result;
    aDuty = duty;
    @(negedge clk);
    if (chkT) chk("R8 done drops after one cycle", done, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    int aRes, aDuty, eRes, eDuty;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    chk("R9 reset result", result, 0);
    chk("R9 reset duty", duty, 0);
    chk("R9 reset done", done, 0);

    // vector table: single steps from a cleared integrator (R1 R2 R4 R5 R6 R7)
    for (int i = 0; i < NVEC; i++) begin
      doReset();
      doCall(int'(VECS[i].r), int'(VECS[i].f), int'($signed(VECS[i].kp)), int'($signed(VECS[i].ki)),
             int'(VECS[i].cl), int'(VECS[i].per), 1'b0, i == 0, aRes, aDuty);
      chk($sformatf("R4 R5 R6 vector %0d result", i), aRes, int'(VECS[i].expRes));
      chk($sformatf("R7 vector %0d duty", i), aDuty, int'(VECS[i].expDuty));
    end

    // R2 accumulation, R8 extra start while busy is ignored, R1 late input changes ignored
    doReset();
    for (int n = 1; n <= 3; n++) begin
      doCall(600, 500, 0, 8192, 30145, 1000, 1'b1, 1'b1, aRes, aDuty);
      chk("R2 R8 accumulated result", aRes, 800 * n);
    end

    // R9: reset mid-run clears integrator
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 result cleared", result, 0);
    chk("R9 duty cleared", duty, 0);
    doCall(600, 500, 0, 0, 30145, 1000, 1'b0, 1'b0, aRes, aDuty);
    chk("R9 integral sum cleared", aRes, 0);

    // R3: drive integrator into positive saturation and back
    doReset();
    for (int n = 0; n < 530; n++) begin
      doCall(1023, 0, 0, 32767, 32767, 65535, 1'b0, 1'b0, aRes, aDuty);
      modelStep(1023, 0, 0, 32767, 32767, 65535, eRes, eDuty);
      chk("R3 saturating rise", aRes, eRes);
    end
    for (int n = 0; n < 530; n++) begin
      doCall(0, 1023, 0, 32767, 32767, 65535, 1'b0, 1'b0, aRes, aDuty);
      modelStep(0, 1023, 0, 32767, 32767, 65535, eRes, eDuty);
      chk("R3 recovery from saturation", aRes, eRes);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule